// File: doc/BRIEF.md
# Streaming Pixel Expander with Palette and Alpha Modulation

This block takes pixels that arrive packed in 32-bit words and widens each one to a 32-bit ARGB value with eight bits per channel. Eleven source layouts are accepted. They include full-width direct color, 16-bit packed color, 8-bit and 4-bit palette indices with or without an alpha field, and alpha-only glyph data. Palette indices are resolved through a 256-entry, 24-bit color table. The table is loaded through a plain write port while the block is idle.

A conversion starts with a one-cycle start pulse. The layout, alpha handling, fixed alpha, fixed color and pixel count are captured at that pulse. Words enter through a valid/ready stream. The block takes exactly as many words as the pixel count needs, and bits left over in the last word are dropped. Pixels leave through a valid/ready stream, one per handshake. Before a pixel is emitted, its alpha can be kept, overwritten with the fixed alpha, or scaled by the fixed alpha with rounding.

Top module: `pixel_expand`

## Requirements
- R1: Direct layouts by mode code: 0 = A[31:24] R[23:16] G[15:8] B[7:0]; 1 = R[23:16] G[15:8] B[7:0]; 2 = R[15:11] G[10:5] B[4:0]; 3 = A[15] R[14:10] G[9:5] B[4:0]; 4 = A[15:12] R[11:8] G[7:4] B[3:0]. A field narrower than 8 bits is widened by appending its top bits below it (5-bit v gives v<<3|v>>2, 6-bit v gives v<<2|v>>4, 4-bit v gives v<<4|v). A 1-bit alpha gives 0x00 or 0xFF. Layouts without alpha give alpha 0xFF.
- R2: Palette layouts: 5 = 8-bit index; 6 = alpha nibble [7:4] above index nibble [3:0]; 7 = alpha [15:8] above 8-bit index [7:0]; 8 = 4-bit index. RGB is the table entry at the index, and 4-bit indices address entries 0 to 15. Modes 5 and 8 give alpha 0xFF.
- R3: Alpha-only layouts, 9 = 8-bit alpha and 10 = 4-bit alpha (widened as in R1), take RGB from the fixed color captured at start.
- R4: Pixels are taken from the word stream least-significant bit first, back to back. Several narrow pixels share a word, with the earlier pixel in the lower bits, and a 24-bit pixel may span two words.
- R5: Alpha handling code 0 keeps the pixel alpha, 1 substitutes the fixed alpha, 2 gives (p + 128 + ((p + 128) >> 8)) >> 8 with p = pixel alpha times fixed alpha, and 3 keeps the pixel alpha.
- R6: A start with a mode code of 11 to 15 sets the configuration error output and starts nothing: busy and in_ready stay low. The next accepted start clears the error.
- R7: A table write while busy is dropped, leaving the entry unchanged, and sets the table error output. The next legal start clears that output.
- R8: A conversion emits exactly the requested number of pixels and accepts exactly ceil(count*bits/32) words. in_ready is low whenever the block is not busy.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R10: A start pulse while busy is ignored. The running conversion keeps the settings it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion with the cfg_* values |
| cfg_mode | input | 4 | Source layout code |
| cfg_amode | input | 2 | Alpha handling code |
| cfg_alpha | input | 8 | Fixed alpha |
| cfg_color | input | 24 | Fixed RGB for alpha-only layouts |
| cfg_count | input | CNT_W | Number of pixels |
| busy | output | 1 | Conversion in progress |
| cfg_err | output | 1 | Last start had an illegal layout |
| in_valid | input | 1 | Source word valid |
| in_ready | output | 1 | Source word accepted |
| in_data | input | 32 | Packed source word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel accepted downstream |
| out_data | output | 32 | ARGB pixel |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 8 | Table write index |
| lut_wdata | input | 24 | Table write RGB |
| lut_err | output | 1 | A table write was refused while busy |

## Verification
Every layout is run on hashed word streams, so the channel fields take varied values and the widening and bit order are exercised rather than a few fixed constants. Odd pixel counts on 24-bit and 16-bit layouts separate correct straddling and leftover-bit dropping from word-aligned behaviour. Palette runs read a table whose entries all differ, so a wrong nibble or byte choice for the index shows as a wrong color. One run repeats a single index after a refused write, which shows whether the old entry survived. The alpha codes are run with fixed alphas of 0x40, 0x80 and 0xFF, where truncation and rounding give different results. A stalling output pattern across all runs checks hold behaviour and exact pixel counts together.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam logic [3:0] MD_ARGB32 = 4'd0;
  localparam logic [3:0] MD_RGB24  = 4'd1;
  localparam logic [3:0] MD_RGB16  = 4'd2;
  localparam logic [3:0] MD_A1RGB  = 4'd3;
  localparam logic [3:0] MD_ARGB16 = 4'd4;
  localparam logic [3:0] MD_IX8    = 4'd5;
  localparam logic [3:0] MD_AIX44  = 4'd6;
  localparam logic [3:0] MD_AIX88  = 4'd7;
  localparam logic [3:0] MD_IX4    = 4'd8;
  localparam logic [3:0] MD_ALF8   = 4'd9;
  localparam logic [3:0] MD_ALF4   = 4'd10;

  localparam logic [1:0] AM_KEEP = 2'd0;
  localparam logic [1:0] AM_SET  = 2'd1;
  localparam logic [1:0] AM_MUL  = 2'd2;

  function automatic logic [5:0] bits_per_pix(input logic [3:0] m);
    case (m)
      MD_ARGB32:                     return 6'd32;
      MD_RGB24:                      return 6'd24;
      MD_RGB16, MD_A1RGB, MD_ARGB16,
      MD_AIX88:                      return 6'd16;
      MD_IX8, MD_AIX44, MD_ALF8:     return 6'd8;
      MD_IX4, MD_ALF4:               return 6'd4;
      default:                       return 6'd0;
    endcase
  endfunction

  function automatic logic mode_ok(input logic [3:0] m);
    return m <= MD_ALF4;
  endfunction

  function automatic logic [7:0] wid4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic [7:0] wid5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] wid6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction
endpackage

// File: rtl/pfc_unpack.sv
module pfc_unpack #(
  parameter int WORD_W = 32,
  parameter int NEED_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NEED_W-1:0] load_bits,
  input  logic [5:0]        pix_w,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pop,
  output logic [WORD_W-1:0] pix_bits,
  output logic              have_pix
);
  localparam int ACC_W  = 2 * WORD_W;
  localparam int FILL_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [NEED_W-1:0] need_q, need_d;
  logic              push;

  assign in_ready = (need_q != '0) && (fill_q <= FILL_W'(WORD_W));
  assign push     = in_valid && in_ready;
  assign have_pix = fill_q >= FILL_W'(pix_w);
  assign pix_bits = acc_q[WORD_W-1:0];

  always_comb begin
    acc_d  = acc_q;
    fill_d = fill_q;
    need_d = need_q;
    if (load) begin
      acc_d  = '0;
      fill_d = '0;
      need_d = load_bits;
    end else begin
      if (push) begin
        acc_d  = acc_d | ({{WORD_W{1'b0}}, in_data} << fill_q);
        fill_d = fill_d + FILL_W'(WORD_W);
        need_d = (need_q > NEED_W'(WORD_W)) ? need_q - NEED_W'(WORD_W) : '0;
      end
      if (pop) begin
        acc_d  = acc_d >> pix_w;
        fill_d = fill_d - FILL_W'(pix_w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
      need_q <= '0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
      need_q <= need_d;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> fill_q <= FILL_W'(ACC_W)) else $error("accumulator overfilled"); // R4
endmodule

// File: rtl/pfc_lut.sv
module pfc_lut #(
  parameter int DEPTH = 256,
  parameter int DW    = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pfc_decode.sv
module pfc_decode
  import pfc_pkg::*;
(
  input  logic [3:0]  mode,
  input  logic [31:0] raw,
  input  logic [23:0] lut_rgb,
  input  logic [23:0] fix_rgb,
  output logic [7:0]  idx,
  output logic [31:0] argb
);
  always_comb begin
    idx  = '0;
    argb = '0;
    case (mode)
      MD_ARGB32: argb = raw;
      MD_RGB24:  argb = {8'hFF, raw[23:0]};
      MD_RGB16:  argb = {8'hFF, wid5(raw[15:11]), wid6(raw[10:5]), wid5(raw[4:0])};
      MD_A1RGB:  argb = {{8{raw[15]}}, wid5(raw[14:10]), wid5(raw[9:5]), wid5(raw[4:0])};
      MD_ARGB16: argb = {wid4(raw[15:12]), wid4(raw[11:8]), wid4(raw[7:4]), wid4(raw[3:0])};
      MD_IX8: begin
        idx  = raw[7:0];
        argb = {8'hFF, lut_rgb};
      end
      MD_AIX44: begin
        idx  = {4'd0, raw[3:0]};
        argb = {wid4(raw[7:4]), lut_rgb};
      end
      MD_AIX88: begin
        idx  = raw[7:0];
        argb = {raw[15:8], lut_rgb};
      end
      MD_IX4: begin
        idx  = {4'd0, raw[3:0]};
        argb = {8'hFF, lut_rgb};
      end
      MD_ALF8:   argb = {raw[7:0], fix_rgb};
      MD_ALF4:   argb = {wid4(raw[3:0]), fix_rgb};
      default:   argb = '0;
    endcase
  end
endmodule

// File: rtl/pfc_alpha.sv
module pfc_alpha
  import pfc_pkg::*;
(
  input  logic [1:0]  amode,
  input  logic [7:0]  fixa,
  input  logic [31:0] argb_in,
  output logic [31:0] argb_out
);
  logic [15:0] prod;
  logic [16:0] rnd1, rnd2;

  always_comb begin
    prod = argb_in[31:24] * fixa;
    rnd1 = {1'b0, prod} + 17'd128;
    rnd2 = rnd1 + (rnd1 >> 8);
    case (amode)
      AM_SET:  argb_out = {fixa, argb_in[23:0]};
      AM_MUL:  argb_out = {rnd2[15:8], argb_in[23:0]};
      default: argb_out = argb_in;
    endcase
  end
endmodule

// File: rtl/pixel_expand.sv
module pixel_expand
  import pfc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int LUT_DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       cfg_mode,
  input  logic [1:0]       cfg_amode,
  input  logic [7:0]       cfg_alpha,
  input  logic [23:0]      cfg_color,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             busy,
  output logic             cfg_err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  input  logic             lut_we,
  input  logic [7:0]       lut_addr,
  input  logic [23:0]      lut_wdata,
  output logic             lut_err
);
  localparam int NEED_W = CNT_W + 6;
  localparam int LUT_AW = $clog2(LUT_DEPTH);

  logic [3:0]       mode_q, mode_d;
  logic [1:0]       amode_q, amode_d;
  logic [7:0]       alpha_q, alpha_d;
  logic [23:0]      color_q, color_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             cerr_q, cerr_d, lerr_q, lerr_d;
  logic             ov_q, ov_d;
  logic [31:0]      od_q, od_d;

  logic             start_acc, start_ok, pop, have_pix;
  logic [31:0]      pix_bits, argb_raw, argb_mod;
  logic [7:0]       idx;
  logic [23:0]      lut_rgb;
  logic [NEED_W-1:0] need_bits;

  assign busy      = left_q != '0;
  assign start_acc = start && !busy;
  assign start_ok  = start_acc && mode_ok(cfg_mode);
  assign pop       = busy && have_pix && (!ov_q || out_ready);
  assign need_bits = NEED_W'(cfg_count) * NEED_W'(bits_per_pix(cfg_mode));

  pfc_unpack #(.WORD_W(32), .NEED_W(NEED_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .load_bits(need_bits),
    .pix_w(bits_per_pix(mode_q)), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pop(pop), .pix_bits(pix_bits), .have_pix(have_pix)
  );

  pfc_lut #(.DEPTH(LUT_DEPTH), .DW(24)) u_lut (
    .clk(clk), .we(lut_we && !busy), .waddr(lut_addr[LUT_AW-1:0]),
    .wdata(lut_wdata), .raddr(idx[LUT_AW-1:0]), .rdata(lut_rgb)
  );

  pfc_decode u_dec (
    .mode(mode_q), .raw(pix_bits), .lut_rgb(lut_rgb), .fix_rgb(color_q),
    .idx(idx), .argb(argb_raw)
  );

  pfc_alpha u_alpha (
    .amode(amode_q), .fixa(alpha_q), .argb_in(argb_raw), .argb_out(argb_mod)
  );

  always_comb begin
    mode_d  = mode_q;
    amode_d = amode_q;
    alpha_d = alpha_q;
    color_d = color_q;
    left_d  = left_q;
    cerr_d  = cerr_q;
    lerr_d  = lerr_q;
    ov_d    = ov_q;
    od_d    = od_q;
    if (start_acc) cerr_d = !mode_ok(cfg_mode);
    if (start_ok) begin
      mode_d  = cfg_mode;
      amode_d = cfg_amode;
      alpha_d = cfg_alpha;
      color_d = cfg_color;
      left_d  = cfg_count;
      lerr_d  = 1'b0;
    end else if (pop) begin
      left_d  = left_q - 1'b1;
    end
    if (lut_we && busy) lerr_d = 1'b1;
    if (pop) begin
      ov_d = 1'b1;
      od_d = argb_mod;
    end else if (out_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      amode_q <= '0;
      alpha_q <= '0;
      color_q <= '0;
      left_q  <= '0;
      cerr_q  <= 1'b0;
      lerr_q  <= 1'b0;
      ov_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      mode_q  <= mode_d;
      amode_q <= amode_d;
      alpha_q <= alpha_d;
      color_q <= color_d;
      left_q  <= left_d;
      cerr_q  <= cerr_d;
      lerr_q  <= lerr_d;
      ov_q    <= ov_d;
      od_q    <= od_d;
    end
  end

  assign cfg_err   = cerr_q;
  assign lut_err   = lerr_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)) else $error("output dropped"); // R9
  AST_IDLE_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready) else $error("word accepted while idle"); // R8
  AST_LUT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we && busy |=> lut_err) else $error("busy table write not flagged"); // R7
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (cfg_mode > 4'd10) |=> cfg_err && !busy) else $error("illegal mode started"); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(mode_q) && $stable(amode_q)) else $error("start while busy changed config"); // R10
endmodule

// File: tb/sim_pixel_expand.sv
`timescale 1ns/1ps
module sim_pixel_expand;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfg_mode = '0;
  logic [1:0]  cfg_amode = '0;
  logic [7:0]  cfg_alpha = '0;
  logic [23:0] cfg_color = '0;
  logic [15:0] cfg_count = '0;
  logic        busy, cfg_err, in_ready, out_valid, lut_err;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        lut_we = 1'b0;
  logic [7:0]  lut_addr = '0;
  logic [23:0] lut_wdata = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [23:0] lut_m [256];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  pixel_expand #(.CNT_W(16), .LUT_DEPTH(256)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_amode(cfg_amode), .cfg_alpha(cfg_alpha), .cfg_color(cfg_color),
    .cfg_count(cfg_count), .busy(busy), .cfg_err(cfg_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata), .lut_err(lut_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int bpp_ref(input int m);
    case (m)
      0: return 32;
      1: return 24;
      2, 3, 4, 7: return 16;
      5, 6, 9: return 8;
      8, 10: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] rep(input int v, input int w);
    return 8'((v << (8 - w)) | (v >> (2 * w - 8)));
  endfunction

  function automatic logic [31:0] ref_pix(input int m, input logic [31:0] r,
      input logic [23:0] col, input int am, input int fa);
    logic [7:0] a;
    logic [23:0] rgb;
    int p;
    a = 8'hFF;
    rgb = '0;
    case (m)
      0: begin a = r[31:24]; rgb = r[23:0]; end
      1: rgb = r[23:0];
      2: rgb = {rep(int'(r[15:11]), 5), rep(int'(r[10:5]), 6), rep(int'(r[4:0]), 5)};
      3: begin a = r[15] ? 8'hFF : 8'h00;
               rgb = {rep(int'(r[14:10]), 5), rep(int'(r[9:5]), 5), rep(int'(r[4:0]), 5)}; end
      4: begin a = rep(int'(r[15:12]), 4);
               rgb = {rep(int'(r[11:8]), 4), rep(int'(r[7:4]), 4), rep(int'(r[3:0]), 4)}; end
      5: rgb = lut_m[r[7:0]];
      6: begin a = rep(int'(r[7:4]), 4); rgb = lut_m[{4'd0, r[3:0]}]; end
      7: begin a = r[15:8]; rgb = lut_m[r[7:0]]; end
      8: rgb = lut_m[{4'd0, r[3:0]}];
      9: begin a = r[7:0]; rgb = col; end
      10: begin a = rep(int'(r[3:0]), 4); rgb = col; end
      default: ;
    endcase
    if (am == 1) a = 8'(fa);
    else if (am == 2) begin
      p = int'(a) * fa;
      a = 8'((p + 128 + ((p + 128) >> 8)) >> 8);
    end
    return {a, rgb};
  endfunction

  task automatic do_start(input int m, input int am, input int fa, input logic [23:0] col, input int cnt);
    @(negedge clk);
    cfg_mode  = 4'(m);
    cfg_amode = 2'(am);
    cfg_alpha = 8'(fa);
    cfg_color = col;
    cfg_count = 16'(cnt);
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic lut_write(input int a, input logic [23:0] d, input bit upd);
    @(negedge clk);
    lut_we    = 1'b1;
    lut_addr  = 8'(a);
    lut_wdata = d;
    if (upd) lut_m[a] = d;
    @(negedge clk);
    lut_we    = 1'b0;
  endtask

  task automatic run_frame(input int m, input int am, input int fa, input logic [23:0] col,
      input int cnt, input bit usefix, input logic [31:0] fixw, input bit poke, input string tag);
    logic [31:0] wq [$];
    logic [31:0] raw;
    int bp, nw, pos;
    bp = bpp_ref(m);
    nw = (cnt * bp + 31) / 32;
    for (int k = 0; k < nw; k++)
      wq.push_back(usefix ? fixw : (32'(k) * 32'h9E3779B9) ^ (32'(m * 131 + cnt) * 32'h85EBCA6B) ^ 32'h5BD1E995);
    for (int i = 0; i < cnt; i++) begin
      raw = '0;
      for (int k = 0; k < bp; k++) begin
        pos = i * bp + k;
        raw[k] = wq[pos / 32][pos % 32];
      end
      exp_q.push_back(ref_pix(m, raw, col, am, fa));
      tag_q.push_back(tag);
    end
    do_start(m, am, fa, col, cnt);
    fork
      begin
        for (int k = 0; k < nw; k++) begin
          in_data  = wq[k];
          in_valid = 1'b1;
          while (!in_ready) @(negedge clk);
          @(negedge clk);
          in_valid = 1'b0;
          if (k % 3 == 2) @(negedge clk);
        end
      end
      begin
        if (poke) begin
          repeat (3) @(negedge clk);
          lut_write(5, 24'h123456, 1'b0);
          do_start(9, 1, 8'h11, 24'hABCDEF, 3);
        end
      end
    join
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Output monitor: compares every accepted pixel against the model queue.
  initial begin
    logic        held;
    logic [31:0] held_d;
    logic [31:0] e;
    string       t;
    held = 1'b0;
    held_d = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 5) != 3;
      #1;
      if (held) check(out_valid && out_data == held_d, "R9 hold", out_data, held_d);
      held = out_valid && !out_ready;
      held_d = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R8 extra pixel", out_data, 32'h0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R9 reset out_valid", 32'(out_valid), 0);
    check(!in_ready && !busy, "R8 reset in_ready", 32'(in_ready), 0);
    check(!cfg_err && !lut_err, "R6 reset flags", {30'd0, cfg_err, lut_err}, 0);

    run_frame(0, 0, 0, 24'h0, 3, 0, 0, 0, "R1 argb32");
    run_frame(1, 0, 0, 24'h0, 5, 0, 0, 0, "R4 rgb24 straddle");
    run_frame(2, 0, 0, 24'h0, 4, 0, 0, 0, "R1 rgb16");
    run_frame(3, 0, 0, 24'h0, 5, 0, 0, 0, "R1 a1rgb");
    run_frame(4, 0, 0, 24'h0, 3, 0, 0, 0, "R8 argb16 leftover");

    for (int i = 0; i < 256; i++)
      lut_write(i, {8'(i) ^ 8'hA5, ~8'(i), 8'(i * 3)}, 1'b1);

    run_frame(5, 0, 0, 24'h0, 6, 0, 0, 0, "R2 ix8");
    run_frame(6, 0, 0, 24'h0, 5, 0, 0, 0, "R2 aix44");
    run_frame(7, 0, 0, 24'h0, 3, 0, 0, 0, "R2 aix88");
    run_frame(8, 0, 0, 24'h0, 9, 0, 0, 0, "R4 ix4 nibble order");
    run_frame(9, 0, 0, 24'h336699, 5, 0, 0, 0, "R3 alf8");
    run_frame(10, 0, 0, 24'hC0FFEE, 7, 0, 0, 0, "R3 alf4");

    run_frame(0, 1, 8'h40, 24'h0, 4, 0, 0, 0, "R5 set");
    run_frame(4, 2, 8'h80, 24'h0, 6, 0, 0, 0, "R5 mul 0x80");
    run_frame(7, 2, 8'hFF, 24'h0, 4, 0, 0, 0, "R5 mul 0xFF");
    run_frame(3, 3, 8'h22, 24'h0, 3, 0, 0, 0, "R5 code3 keep");

    in_valid = 1'b1;
    in_data  = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    check(!in_ready, "R8 word refused when done", 32'(in_ready), 0);
    in_valid = 1'b0;

    do_start(11, 0, 0, 24'h0, 4);
    check(cfg_err == 1'b1, "R6 illegal mode flag", 32'(cfg_err), 1);
    check(!busy && !in_ready, "R6 illegal mode idle", {30'd0, busy, in_ready}, 0);

    run_frame(5, 0, 0, 24'h0, 40, 0, 0, 1, "R10 start ignored while busy");
    check(cfg_err == 1'b0, "R6 error cleared by legal start", 32'(cfg_err), 0);
    check(lut_err == 1'b1, "R7 busy write flagged", 32'(lut_err), 1);
    run_frame(5, 0, 0, 24'h0, 4, 1, 32'h05050505, 0, "R7 entry unchanged");
    check(lut_err == 1'b0, "R7 flag cleared by start", 32'(lut_err), 0);

    check(exp_q.size() == 0, "R8 all pixels emitted", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule